// File: doc/BRIEF.md
# Programmable Phase Pulse Generator

This block divides a train of single-cycle input pulses by 2^N, where N is the number of binary toggle stages. Each toggle stage is fed through a skip gate. A skip gate normally forwards every pulse from the stage before it. When a skip request is pending, it drops exactly one arriving pulse and then forwards pulses again. Dropping one pulse in front of stage k holds the whole counter back by 2^k input periods. A phase word of N bits therefore delays the periodic output by exactly the value of the word, counted in input periods.

Software or a sequencer places the phase word on the load port and raises the load strobe for one cycle. Each set bit becomes one pending skip request for the gate in front of the stage with the same bit position. Requests add up, so a second load on top of pending requests delays the output further. The output is a one-cycle pulse, raised in the cycle after the input pulse that completes a full cycle of the final stage. Reset is synchronous and active high.

Top module: `phase_pulse_gen`

## Requirements
- R1: With no skips pending, `pulse_out` is high for exactly one cycle, in the cycle after every 2^N-th `pulse_in` pulse counted from reset. With N = 3 it follows input pulses 8, 16, 24 and so on.
- R2: A skip gate with no pending request forwards every incoming pulse unchanged.
- R3: A skip gate with a pending request swallows the next pulse that reaches it, and it forwards pulses again once its requests are used up.
- R4: One skip at stage k, which is phase-word bit k with bit 0 as the least significant bit, delays every later output pulse by 2^k input periods.
- R5: After a load of word K from the reset state, output pulses follow input pulses K + m*2^N for m >= 1. In a 3-bit instance the words 0 to 7 give eight distinct phase positions.
- R6: A load while earlier requests are still pending adds its bits to them, so the total delay is the sum of the loaded words.
- R7: A load in the same cycle as an input pulse affects only later pulses. The pulse of that cycle is either forwarded or swallowed according to the requests that were already pending. If a gate swallows a pulse in the same cycle as a new request for that gate arrives, the new request stays pending.
- R8: Each gate counts at most 2^PEND_W - 1 pending requests, and further requests to a full gate are dropped. With PEND_W = 2, five loads of word 1 give a delay of 3.
- R9: A synchronous reset clears all toggle stages, all pending requests and `pulse_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pulse_in | input | 1 | One-cycle input pulse strobe |
| load | input | 1 | One-cycle strobe that posts a skip request for each set bit of `phase_word` |
| phase_word | input | STAGES | Phase delay in input periods |
| pulse_out | output | 1 | One-cycle divided output pulse |

## Verification
A load can arrive in the same cycle as an input pulse. If a gate already has a request pending in that cycle, it swallows the pulse while the new request is being posted. The bench provokes both cases. In the first, a load with word 3 rides on the very first pulse after reset. In the second, a load with word 1 is followed by a pulse that carries a second load with word 1. Each case is judged by the input pulse counts at which `pulse_out` rises, which must be 11 and 10 respectively. These counts show that the coincident pulse obeyed only the earlier requests and that no request was lost.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
   // Limits used by the elaboration checks of the generator.
   localparam int unsigned PPG_MAX_STAGES = 32;
   localparam int unsigned PPG_MAX_PEND_W = 8;

   // Weight of one skip at a stage, in input periods.
   function automatic int unsigned ppg_stage_weight(input int unsigned stage);
      return 32'd1 << stage;
   endfunction
endpackage

// File: rtl/ppg_skip_gate.sv
module ppg_skip_gate #(
   parameter int unsigned PEND_W = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic pulse_i,
   input  logic req_i,
   output logic pulse_o
);
   localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

   logic [PEND_W-1:0] pend_q;
   logic [PEND_W-1:0] pend_mid;
   logic [PEND_W-1:0] pend_d;
   logic              take;

   assign take    = pulse_i && (pend_q != '0);
   assign pulse_o = pulse_i && (pend_q == '0);

   always_comb begin
      pend_mid = take ? pend_q - 1'b1 : pend_q;
      pend_d   = pend_mid;
      if (req_i && (pend_mid != PEND_MAX)) begin
         pend_d = pend_mid + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q <= '0;
      end else begin
         pend_q <= pend_d;
      end
   end

   // R3
   skip_consume_chk: assert property (@(posedge clk) disable iff (rst)
      (pulse_i && (pend_q != '0) && !req_i) |=> (pend_q == $past(pend_q) - 1'b1));

   // R2
   skip_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!pulse_i && !req_i) |=> $stable(pend_q));
endmodule

// File: rtl/ppg_toggle_stage.sv
module ppg_toggle_stage (
   input  logic clk,
   input  logic rst,
   input  logic pulse_i,
   output logic carry_o
);
   logic state_q;

   assign carry_o = pulse_i && state_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= 1'b0;
      end else if (pulse_i) begin
         state_q <= ~state_q;
      end
   end

   // R1
   toggle_flip_chk: assert property (@(posedge clk) disable iff (rst)
      pulse_i |=> (state_q != $past(state_q)));

   // R1
   toggle_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !pulse_i |=> $stable(state_q));
endmodule

// File: rtl/phase_pulse_gen.sv
module phase_pulse_gen #(
   parameter int unsigned STAGES = 10,
   parameter int unsigned PEND_W = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              pulse_in,
   input  logic              load,
   input  logic [STAGES-1:0] phase_word,
   output logic              pulse_out
);
   import ppg_pkg::*;

   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < 1 || STAGES > PPG_MAX_STAGES) begin : g_bad_stages
      $error("phase_pulse_gen: STAGES out of range");
   end
   if (PEND_W < 1 || PEND_W > PPG_MAX_PEND_W) begin : g_bad_pend
      $error("phase_pulse_gen: PEND_W out of range");
   end

   logic [STAGES:0]   link;
   logic [STAGES-1:0] gated;
   logic              out_q;

   assign link[0] = pulse_in;

   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      ppg_skip_gate #(.PEND_W(PEND_W)) gate_i (
         .clk     (clk),
         .rst     (rst),
         .pulse_i (link[k]),
         .req_i   (load && phase_word[k]),
         .pulse_o (gated[k])
      );
      ppg_toggle_stage tff_i (
         .clk     (clk),
         .rst     (rst),
         .pulse_i (gated[k]),
         .carry_o (link[k+1])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_q <= 1'b0;
      end else begin
         out_q <= link[LAST+1];
      end
   end

   assign pulse_out = out_q;

   // R1
   out_single_chk: assert property (@(posedge clk) disable iff (rst)
      pulse_out |=> !pulse_out);

   // R1
   out_needs_in_chk: assert property (@(posedge clk) disable iff (rst)
      !pulse_in |=> !pulse_out);
endmodule

// File: tb/phase_pulse_gen_tb_top.sv
module phase_pulse_gen_tb_top;
   localparam int unsigned N = 3;
   localparam int unsigned PERIOD = 8;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         pulse_in = 1'b0;
   logic         load = 1'b0;
   logic [N-1:0] phase_word = '0;
   logic         pulse_out;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   phase_pulse_gen #(.STAGES(N), .PEND_W(2)) dut_i (
      .clk        (clk),
      .rst        (rst),
      .pulse_in   (pulse_in),
      .load       (load),
      .phase_word (phase_word),
      .pulse_out  (pulse_out)
   );

   task automatic check(input logic act, input logic exp, input string req, input int n);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s pulse %0d: pulse_out actual %0b expected %0b", req, n, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; pulse_in = 1'b0; load = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic do_load(input logic [N-1:0] w);
      load = 1'b1; phase_word = w;
      @(negedge clk);
      load = 1'b0; phase_word = '0;
      @(negedge clk);
   endtask

   // Drives n pulses; the first may carry a load. Output expected after pulse i when i > k and (i-k) % PERIOD == 0.
   task automatic train(input int k, input int n, input logic first_ld, input logic [N-1:0] w, input string req);
      for (int i = 1; i <= n; i++) begin
         pulse_in = 1'b1;
         if (i == 1 && first_ld) begin
            load = 1'b1; phase_word = w;
         end
         @(negedge clk);
         pulse_in = 1'b0; load = 1'b0; phase_word = '0;
         check(pulse_out, (i > k) && ((i - k) % PERIOD == 0), req, i);
         @(negedge clk);
         check(pulse_out, 1'b0, req, i);
      end
   endtask

   task automatic t_reset_state();
      do_reset();
      check(pulse_out, 1'b0, "R9", 0);
   endtask

   task automatic t_plain_divide();
      do_reset();
      train(0, 3 * PERIOD, 1'b0, '0, "R1 R2");
   endtask

   task automatic t_every_word();
      for (int k = 0; k < PERIOD; k++) begin
         do_reset();
         do_load(k[N-1:0]);
         train(k, 3 * PERIOD, 1'b0, '0, (k == 1 || k == 2 || k == 4) ? "R4 R3" : "R5");
      end
   endtask

   task automatic t_accumulate();
      do_reset();
      do_load(3'd3);
      do_load(3'd1);
      train(4, 3 * PERIOD, 1'b0, '0, "R6");
   endtask

   task automatic t_mid_stream();
      do_reset();
      train(0, 2 * PERIOD, 1'b0, '0, "R1");
      do_load(3'd5);
      train(5, 3 * PERIOD, 1'b0, '0, "R5 R6");
   endtask

   task automatic t_coincide();
      do_reset();
      train(3, 3 * PERIOD, 1'b1, 3'd3, "R7");
      do_reset();
      do_load(3'd1);
      train(2, 3 * PERIOD, 1'b1, 3'd1, "R7 R3");
   endtask

   task automatic t_saturate();
      do_reset();
      for (int j = 0; j < 5; j++) do_load(3'd1);
      train(3, 3 * PERIOD, 1'b0, '0, "R8");
   endtask

   task automatic t_reset_clears();
      do_reset();
      do_load(3'd5);
      train(0, 2, 1'b0, '0, "R9");
      do_reset();
      check(pulse_out, 1'b0, "R9", 0);
      train(0, 2 * PERIOD, 1'b0, '0, "R9");
   endtask

   initial begin
      #(20 * 20000);
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      t_reset_state();
      t_plain_divide();
      t_every_word();
      t_accumulate();
      t_mid_stream();
      t_coincide();
      t_saturate();
      t_reset_clears();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule